// File: doc/BRIEF.md
# Split Serial Register Transfer Unit

This block models the serial-access side of a dual-port video memory. The serial register holds two halves of `HALF_WORDS` words each. One half, the active one, streams words out to a serial consumer or takes words in from a serial producer. Meanwhile the other half, the idle one, exchanges a whole half-row with the memory array. A flag output names the active half. The flag flips when the last word of the active half is handed over. The serial pointer then moves on into the other half, which by then holds fresh data.

Transfer cycles are decoded from a set of strobe and select inputs at the falling edge of the row strobe. All strobes are sampled in the single clock domain of the block. A full transfer moves the whole register at once. It sets the serial port direction and the starting tap position. A split transfer moves only the idle half. It is accepted only in the matching port direction and only once a hold-off window after the last flag flip has elapsed. Anything illegal is dropped and reported by a one-cycle error pulse.

The memory array is not part of the block. The block reaches it one word per clock through a simple request port. The array answers a read one cycle after the request. The serial data ports use valid/ready handshakes, with one word moving per cycle in which both are high. The block lowers its own valid or ready signal to apply back-pressure. It does so during a full transfer, and during a split transfer when the pointer sits on the last word of the active half. The serial producer or consumer may hold its side low for any number of cycles.

Top module: `vsam_split_xfer`

## Requirements
- R1: After reset, half_flag, sout_valid, sin_ready, xfer_busy and xfer_err are all 0, and ram_req stays 0 until a transfer is accepted.
- R2: A transfer is recognised only in a cycle where row_stb_n is sampled low after being sampled high, with xfer_gate_n low and col_stb_n high. The kind of transfer is set as follows:
  - func_sel=0 with both wr_en_lo_n and wr_en_hi_n high is a full read.
  - func_sel=0 with either enable low is a masked full write.
  - func_sel=1 with both enables high is a split read.
  - func_sel=1 with either enable low is a split write.
  A fall with xfer_gate_n high or col_stb_n low is ignored: no memory access and no error.
- R3: A full read copies memory row row_addr, column c, into register word c for all 2*HALF_WORDS words. It loads the pointer with tap_addr and puts the serial port in output mode.
- R4: A masked full write writes register word c into column c of row row_addr for every word. Only bits where dq_mask is 1 are changed. It loads the pointer with tap_addr and puts the serial port in input mode.
- R5: A split read copies the idle half's columns of the row into the idle half only. The active half keeps streaming while this happens.
- R6: A split write writes the idle half's words into the same columns of the row, under dq_mask. All other columns of the row stay unchanged.
- R7: In output mode, sout_data is the word at the pointer. In input mode, sin_data is stored at the pointer. The pointer advances on each handshake, wraps from the last word of a half to the first word of the other half, and wraps from word 2*HALF_WORDS-1 to word 0.
- R8: half_flag equals the pointer's top bit. It therefore flips on the handshake of the last word of the active half.
- R9: A split read is legal only after a full read has set output mode. A split write is legal only after a masked full write has set input mode.
- R10: Let the shift that flipped half_flag happen at one clock edge. A split transfer whose fall is sampled at most GAP_CYC edges after that edge is illegal. One sampled GAP_CYC+1 or more edges after it is legal.
- R11: An illegal transfer, or any transfer decoded while xfer_busy is 1, makes no memory access and leaves the register unchanged. It raises xfer_err for exactly the one cycle after the fall edge.
- R12: While a full transfer is busy, sout_valid and sin_ready are 0. While a split transfer is busy, they are 0 whenever the pointer is on the last word of its half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, transfer decoded on its sampled fall |
| col_stb_n | input | 1 | Column strobe, must be high for a transfer |
| wr_en_lo_n | input | 1 | Low byte write enable, active low |
| wr_en_hi_n | input | 1 | High byte write enable, active low |
| func_sel | input | 1 | 1 selects split transfer |
| xfer_gate_n | input | 1 | Transfer gate, low marks a transfer cycle |
| row_addr | input | ROW_W | Memory row of the transfer |
| tap_addr | input | PTR_W | Start pointer for full transfers |
| dq_mask | input | DATA_W | Per-bit write mask, 1 = write |
| ram_req | output | 1 | Memory word access request |
| ram_we | output | 1 | 1 = write, 0 = read |
| ram_row | output | ROW_W | Row of the access |
| ram_col | output | PTR_W | Column of the access |
| ram_wdata | output | DATA_W | Write data |
| ram_wmask | output | DATA_W | Per-bit write mask |
| ram_rdata | input | DATA_W | Read data, one cycle after the request |
| sout_valid | output | 1 | Serial output word available |
| sout_ready | input | 1 | Consumer takes the word |
| sout_data | output | DATA_W | Serial output word |
| sin_valid | input | 1 | Producer offers a word |
| sin_ready | output | 1 | Block accepts a word |
| sin_data | input | DATA_W | Serial input word |
| half_flag | output | 1 | Active half index |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_err | output | 1 | One-cycle pulse on a rejected transfer |

## Verification
A wrong pointer or wrong half selection shows up on the first serial word after the fault. The wrong word appears on sout_data, or the flag flips at the wrong handshake. A split transfer that targets the active half corrupts data that the consumer reads within one half of handshakes. A wrong input-side word shows only later, when a later write transfer lands in the memory row. A bad legality or window decision shows in the cycle after the fall: either xfer_err pulses when it should not, or memory requests start when they should not.

// File: rtl/vsam_pkg.sv
package vsam_pkg;
  typedef enum logic [1:0] {PORT_NONE, PORT_OUT, PORT_IN} port_mode_e;
  typedef enum logic [2:0] {
    XK_NONE, XK_FULL_RD, XK_FULL_WR, XK_SPLIT_RD, XK_SPLIT_WR
  } xfer_kind_e;
endpackage

// File: rtl/vsam_decode.sv
module vsam_decode
  import vsam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_stb_n,
  input  logic       col_stb_n,
  input  logic       wr_en_lo_n,
  input  logic       wr_en_hi_n,
  input  logic       func_sel,
  input  logic       xfer_gate_n,
  input  port_mode_e port_mode,
  input  logic       win_open,
  input  logic       busy,
  output logic       go,
  output xfer_kind_e go_kind,
  output logic       load_ptr,
  output port_mode_e load_mode,
  output logic       err
);
  logic       rs_q;
  logic       fall;
  logic       any_we;
  logic       legal;
  xfer_kind_e kind;

  assign fall   = rs_q && !row_stb_n;
  assign any_we = !wr_en_lo_n || !wr_en_hi_n;

  always_comb begin
    kind = XK_NONE;
    if (fall && !xfer_gate_n && col_stb_n) begin
      if (func_sel) kind = any_we ? XK_SPLIT_WR : XK_SPLIT_RD;
      else          kind = any_we ? XK_FULL_WR  : XK_FULL_RD;
    end
  end

  always_comb begin
    legal = 1'b0;
    if (!busy) begin
      unique case (kind)
        XK_FULL_RD, XK_FULL_WR: legal = 1'b1;
        XK_SPLIT_RD:            legal = (port_mode == PORT_OUT) && win_open;
        XK_SPLIT_WR:            legal = (port_mode == PORT_IN) && win_open;
        default:                legal = 1'b0;
      endcase
    end
  end

  assign go        = (kind != XK_NONE) && legal;
  assign go_kind   = go ? kind : XK_NONE;
  assign load_ptr  = go && ((kind == XK_FULL_RD) || (kind == XK_FULL_WR));
  assign load_mode = (kind == XK_FULL_WR) ? PORT_IN : PORT_OUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b1;
      err  <= 1'b0;
    end else begin
      rs_q <= row_stb_n;
      err  <= (kind != XK_NONE) && !legal;
    end
  end

  // R11: a rejection is a single-cycle pulse
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

// File: rtl/vsam_window.sv
module vsam_window #(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic open_now
);
  localparam int CNT_W = $clog2(GAP_CYC + 2);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(GAP_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= LIM;
    else if (toggle)        cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign open_now = (cnt_q == LIM) && !toggle;

  generate
    if (GAP_CYC > 0) begin : g_chk
      // R10: window closes right after a flag flip
      a_r10_closed_after_flip: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !open_now);
    end
  endgenerate
endmodule

// File: rtl/vsam_seq.sv
module vsam_seq
  import vsam_pkg::*;
#(
  parameter int HALF_WORDS = 256,
  parameter int ROW_W      = 9,
  parameter int DATA_W     = 16,
  parameter int PTR_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  xfer_kind_e        go_kind,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [DATA_W-1:0] mask_in,
  input  logic              active_half,
  input  logic [DATA_W-1:0] sam_word,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ROW_W-1:0]  ram_row,
  output logic [PTR_W-1:0]  ram_col,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] ram_wmask,
  output logic              cap_en,
  output logic [PTR_W-1:0]  cap_col,
  output logic [DATA_W-1:0] cap_data,
  output logic              busy,
  output logic              full_busy,
  output logic              split_busy
);
  localparam logic [PTR_W-1:0] LAST_FULL  = PTR_W'(2 * HALF_WORDS - 1);
  localparam logic [PTR_W-1:0] LAST_SPLIT = PTR_W'(HALF_WORDS - 1);

  logic              issuing_q, wr_q, full_q, rd_v_q;
  logic [PTR_W-1:0]  idx_q, last_q, base_q, rd_col_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] mask_q;
  logic              go_wr, go_full;

  assign go_wr   = (go_kind == XK_FULL_WR) || (go_kind == XK_SPLIT_WR);
  assign go_full = (go_kind == XK_FULL_RD) || (go_kind == XK_FULL_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing_q <= 1'b0;
      wr_q      <= 1'b0;
      full_q    <= 1'b0;
      idx_q     <= '0;
      last_q    <= '0;
      base_q    <= '0;
      row_q     <= '0;
      mask_q    <= '0;
      rd_v_q    <= 1'b0;
      rd_col_q  <= '0;
    end else begin
      if (go) begin
        issuing_q <= 1'b1;
        wr_q      <= go_wr;
        full_q    <= go_full;
        idx_q     <= '0;
        last_q    <= go_full ? LAST_FULL : LAST_SPLIT;
        base_q    <= go_full ? '0 : {~active_half, {(PTR_W-1){1'b0}}};
        row_q     <= row_addr;
        mask_q    <= mask_in;
      end else if (issuing_q) begin
        if (idx_q == last_q) issuing_q <= 1'b0;
        else                 idx_q     <= idx_q + 1'b1;
      end
      rd_v_q   <= issuing_q && !wr_q;
      rd_col_q <= ram_col;
    end
  end

  assign ram_col    = base_q + idx_q;
  assign ram_req    = issuing_q;
  assign ram_we     = issuing_q && wr_q;
  assign ram_row    = row_q;
  assign ram_wdata  = sam_word;
  assign ram_wmask  = mask_q;
  assign cap_en     = rd_v_q;
  assign cap_col    = rd_col_q;
  assign cap_data   = ram_rdata;
  assign busy       = issuing_q || rd_v_q;
  assign full_busy  = busy && full_q;
  assign split_busy = busy && !full_q;

  // R5/R6: split accesses stay in the idle half
  a_r5_split_idle_half: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing_q && !full_q) |-> (ram_col[PTR_W-1] != active_half));
endmodule

// File: rtl/vsam_sam.sv
module vsam_sam
  import vsam_pkg::*;
#(
  parameter int HALF_WORDS = 256,
  parameter int DATA_W     = 16,
  parameter int PTR_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ptr,
  input  port_mode_e        load_mode,
  input  logic [PTR_W-1:0]  tap,
  input  logic              cap_en,
  input  logic [PTR_W-1:0]  cap_col,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [PTR_W-1:0]  rd_col,
  input  logic              full_busy,
  input  logic              split_busy,
  output logic [DATA_W-1:0] rd_word,
  output logic              sout_valid,
  input  logic              sout_ready,
  output logic [DATA_W-1:0] sout_data,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic [DATA_W-1:0] sin_data,
  output logic              flag,
  output logic              toggle,
  output port_mode_e        port_mode
);
  localparam int WORDS = 2 * HALF_WORDS;

  logic [DATA_W-1:0] mem [WORDS];
  logic [PTR_W-1:0]  ptr_q;
  port_mode_e        mode_q;
  logic              at_last, block, fire_out, fire_in;

  assign at_last    = &ptr_q[PTR_W-2:0];
  assign block      = full_busy || (split_busy && at_last);
  assign sout_valid = (mode_q == PORT_OUT) && !block;
  assign sin_ready  = (mode_q == PORT_IN) && !block;
  assign fire_out   = sout_valid && sout_ready;
  assign fire_in    = sin_valid && sin_ready;
  assign toggle     = (fire_out || fire_in) && at_last;
  assign flag       = ptr_q[PTR_W-1];
  assign port_mode  = mode_q;
  assign sout_data  = mem[ptr_q];
  assign rd_word    = mem[rd_col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mode_q <= PORT_NONE;
    end else if (load_ptr) begin
      ptr_q  <= tap;
      mode_q <= load_mode;
    end else if (fire_out || fire_in) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en)  mem[cap_col] <= cap_data;
    if (fire_in) mem[ptr_q]   <= sin_data;
  end

  // R7: the port is never both source and sink
  a_r7_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sout_valid && sin_ready));
  // R8: the flag moves only on a last-word handshake or a full-transfer load
  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(flag) |-> $past(toggle || load_ptr));
  // R5: split read data lands only in the idle half
  a_r5_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && split_busy) |-> (cap_col[PTR_W-1] != flag));
endmodule

// File: rtl/vsam_split_xfer.sv
module vsam_split_xfer
  import vsam_pkg::*;
#(
  parameter int HALF_WORDS = 256,
  parameter int ROW_W      = 9,
  parameter int DATA_W     = 16,
  parameter int GAP_CYC    = 8,
  localparam int PTR_W     = $clog2(2 * HALF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wr_en_lo_n,
  input  logic              wr_en_hi_n,
  input  logic              func_sel,
  input  logic              xfer_gate_n,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [PTR_W-1:0]  tap_addr,
  input  logic [DATA_W-1:0] dq_mask,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ROW_W-1:0]  ram_row,
  output logic [PTR_W-1:0]  ram_col,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] ram_wmask,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              sout_valid,
  input  logic              sout_ready,
  output logic [DATA_W-1:0] sout_data,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic [DATA_W-1:0] sin_data,
  output logic              half_flag,
  output logic              xfer_busy,
  output logic              xfer_err
);
  logic              go, load_ptr, win_open, toggle;
  logic              busy, full_busy, split_busy, cap_en;
  xfer_kind_e        go_kind;
  port_mode_e        load_mode, port_mode;
  logic [PTR_W-1:0]  cap_col;
  logic [DATA_W-1:0] cap_data, sam_word;

  vsam_decode u_decode (
    .clk, .rst_n, .row_stb_n, .col_stb_n, .wr_en_lo_n, .wr_en_hi_n,
    .func_sel, .xfer_gate_n, .port_mode, .win_open, .busy,
    .go, .go_kind, .load_ptr, .load_mode, .err(xfer_err)
  );

  vsam_window #(.GAP_CYC(GAP_CYC)) u_window (
    .clk, .rst_n, .toggle, .open_now(win_open)
  );

  vsam_seq #(
    .HALF_WORDS(HALF_WORDS), .ROW_W(ROW_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_seq (
    .clk, .rst_n, .go, .go_kind, .row_addr, .mask_in(dq_mask),
    .active_half(half_flag), .sam_word, .ram_rdata,
    .ram_req, .ram_we, .ram_row, .ram_col, .ram_wdata, .ram_wmask,
    .cap_en, .cap_col, .cap_data, .busy, .full_busy, .split_busy
  );

  vsam_sam #(
    .HALF_WORDS(HALF_WORDS), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_sam (
    .clk, .rst_n, .load_ptr, .load_mode, .tap(tap_addr),
    .cap_en, .cap_col, .cap_data, .rd_col(ram_col),
    .full_busy, .split_busy, .rd_word(sam_word),
    .sout_valid, .sout_ready, .sout_data,
    .sin_valid, .sin_ready, .sin_data,
    .flag(half_flag), .toggle, .port_mode
  );

  assign xfer_busy = busy;

  // R11: no memory access starts in the cycle after a rejection
  a_r11_no_access_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_err && !$past(busy)) |-> !ram_req);
endmodule

// File: tb/vsam_split_xfer_bench.sv
module vsam_split_xfer_bench;
  localparam int HW = 8, RW = 2, DW = 16, GAP = 4, PW = 4, WN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_stb_n = 1, col_stb_n = 1, wr_en_lo_n = 1, wr_en_hi_n = 1;
  logic func_sel = 0, xfer_gate_n = 1;
  logic [RW-1:0] row_addr = '0;
  logic [PW-1:0] tap_addr = '0;
  logic [DW-1:0] dq_mask = '0;
  logic ram_req, ram_we;
  logic [RW-1:0] ram_row;
  logic [PW-1:0] ram_col;
  logic [DW-1:0] ram_wdata, ram_wmask, ram_rdata, sout_data, sin_data = '0;
  logic sout_valid, sout_ready = 0, sin_valid = 0, sin_ready;
  logic half_flag, xfer_busy, xfer_err;

  always #5 clk = ~clk;

  vsam_split_xfer #(.HALF_WORDS(HW), .ROW_W(RW), .DATA_W(DW), .GAP_CYC(GAP)) u_vsam_split_xfer (
    .clk, .rst_n, .row_stb_n, .col_stb_n, .wr_en_lo_n, .wr_en_hi_n, .func_sel,
    .xfer_gate_n, .row_addr, .tap_addr, .dq_mask, .ram_req, .ram_we, .ram_row,
    .ram_col, .ram_wdata, .ram_wmask, .ram_rdata, .sout_valid, .sout_ready,
    .sout_data, .sin_valid, .sin_ready, .sin_data, .half_flag, .xfer_busy, .xfer_err
  );

  int n_chk = 0, n_fail = 0, ram_acc = 0;
  bit done = 0;
  logic [DW-1:0] mem [4][WN];
  logic [DW-1:0] ram_exp [4][WN];
  logic [DW-1:0] sam_exp [WN];
  logic [DW-1:0] sb_q [$];

  function automatic logic [DW-1:0] init_word(int r, int c);
    return {4'(r), 4'hA, 8'(c * 7 + 1)};
  endfunction

  always @(posedge clk) begin
    if (ram_req) begin
      ram_acc <= ram_acc + 1;
      if (ram_we) mem[ram_row][ram_col] <= (mem[ram_row][ram_col] & ~ram_wmask) | (ram_wdata & ram_wmask);
      else        ram_rdata <= mem[ram_row][ram_col];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each serial output handshake
  always begin
    @(negedge clk); #1;
    if (rst_n && sout_valid && sout_ready) begin
      if (sb_q.size() == 0) chk(0, "R7 unexpected serial word", int'(sout_data), 0);
      else begin
        logic [DW-1:0] e;
        e = sb_q.pop_front();
        chk(sout_data == e, "R7 serial word", int'(sout_data), int'(e));
      end
    end
  end

  task automatic ras(input bit cs_n, input bit gate_n, input bit fs, input bit any_we,
                     input bit hi_b, input int row, input int tap, input int msk,
                     output bit e1, output bit e2);
    col_stb_n = cs_n; xfer_gate_n = gate_n; func_sel = fs;
    wr_en_lo_n = !(any_we && !hi_b); wr_en_hi_n = !(any_we && hi_b);
    row_addr = RW'(row); tap_addr = PW'(tap); dq_mask = DW'(msk);
    row_stb_n = 0;
    @(posedge clk); @(negedge clk);
    e1 = xfer_err;
    row_stb_n = 1; col_stb_n = 1; xfer_gate_n = 1; func_sel = 0;
    wr_en_lo_n = 1; wr_en_hi_n = 1;
    @(negedge clk);
    e2 = xfer_err;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_free();
    for (int i = 0; i < 100 && xfer_busy; i++) @(negedge clk);
  endtask

  task automatic shift_out(input int n);
    int got = 0;
    sout_ready = 1;
    while (got < n) begin
      #1; if (sout_valid) got++;
      @(negedge clk);
    end
    sout_ready = 0;
  endtask

  task automatic shift_in(input int n, input logic [DW-1:0] v);
    int i = 0;
    sin_valid = 1;
    while (i < n) begin
      sin_data = v + DW'(i);
      #1; if (sin_ready) i++;
      @(negedge clk);
    end
    sin_valid = 0;
  endtask

  task automatic cmp_row(input int r, input string tag);
    int bad = 0, a = 0, e = 0;
    for (int c = 0; c < WN; c++)
      if (mem[r][c] !== ram_exp[r][c]) begin
        if (bad == 0) begin a = int'(mem[r][c]); e = int'(ram_exp[r][c]); end
        bad++;
      end
    chk(bad == 0, tag, a, e);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    bit e1, e2;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < WN; c++) begin
        mem[r][c] = init_word(r, c);
        ram_exp[r][c] = init_word(r, c);
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({half_flag, sout_valid, sin_ready, xfer_busy, xfer_err} == 5'b0, "R1 reset outputs",
        int'({half_flag, sout_valid, sin_ready, xfer_busy, xfer_err}), 0);
    // R9 split read before any full transfer
    ras(1, 0, 1, 0, 0, 2, 0, 0, e1, e2);
    chk(e1 == 1, "R9 split read before full read rejected", e1, 1);
    chk(e2 == 0, "R11 error is one cycle", e2, 0);
    idle(3);
    chk(ram_acc == 0, "R11 rejected transfer makes no access", ram_acc, 0);
    chk(sout_valid == 0, "R1 no output before full read", sout_valid, 0);
    // R2 ignored cycles: gate high, column strobe low
    ras(1, 1, 0, 0, 0, 1, 0, 0, e1, e2);
    chk(e1 == 0, "R2 gate-high cycle gives no error", e1, 0);
    ras(0, 0, 0, 0, 0, 1, 0, 0, e1, e2);
    chk(e1 == 0, "R2 column-strobe-low cycle gives no error", e1, 0);
    idle(2);
    chk(ram_acc == 0 && xfer_busy == 0, "R2 ignored cycles make no access", ram_acc, 0);
    // R3 full read row 1, tap 3
    ras(1, 0, 0, 0, 0, 1, 3, 0, e1, e2);
    chk(e1 == 0 && xfer_busy == 1, "R2 full read accepted", int'({e1, xfer_busy}), 1);
    chk(sout_valid == 0 && sin_ready == 0, "R12 port stalled during full transfer", sout_valid, 0);
    ras(1, 0, 1, 0, 0, 2, 0, 0, e1, e2);
    chk(e1 == 1, "R11 transfer while busy rejected", e1, 1);
    wait_free();
    chk(ram_acc == 2 * HW, "R3/R11 full read access count", ram_acc, 2 * HW);
    chk(half_flag == 0 && sout_valid == 1 && sin_ready == 0, "R3 output mode, flag from tap",
        int'({half_flag, sout_valid, sin_ready}), 2);
    for (int c = 0; c < WN; c++) sam_exp[c] = init_word(1, c);
    for (int c = 3; c < 8; c++) sb_q.push_back(sam_exp[c]);
    shift_out(5);
    chk(half_flag == 1, "R8 flag flips after last word of half", half_flag, 1);
    // R10 window
    idle(GAP - 1);
    ras(1, 0, 1, 0, 0, 2, 0, 0, e1, e2);
    chk(e1 == 1, "R10 split read inside window rejected", e1, 1);
    ras(1, 0, 1, 0, 0, 2, 0, 0, e1, e2);
    chk(e1 == 0, "R10 split read after window accepted", e1, 0);
    chk(xfer_busy == 1 && sout_valid == 1, "R5 active half streams during split",
        int'({xfer_busy, sout_valid}), 3);
    for (int c = 8; c < WN; c++) sb_q.push_back(sam_exp[c]);
    for (int c = 0; c < HW; c++) sam_exp[c] = init_word(2, c);
    shift_out(8);
    chk(half_flag == 0, "R8 flag flips back at end of upper half", half_flag, 0);
    for (int c = 0; c < HW; c++) sb_q.push_back(sam_exp[c]);
    shift_out(8);
    chk(sb_q.size() == 0, "R5/R7 wrap into reloaded half drained", sb_q.size(), 0);
    chk(half_flag == 1, "R8 flag after lower half", half_flag, 1);
    // R9 split write in output mode
    idle(GAP + 1);
    ras(1, 0, 1, 1, 0, 0, 0, 16'hFFFF, e1, e2);
    chk(e1 == 1, "R9 split write in output mode rejected", e1, 1);
    // R4 masked full write row 3, tap 10, mask FF00
    ras(1, 0, 0, 1, 0, 3, 10, 16'hFF00, e1, e2);
    chk(e1 == 0, "R4 masked full write accepted", e1, 0);
    wait_free();
    for (int c = 0; c < WN; c++)
      ram_exp[3][c] = (ram_exp[3][c] & 16'h00FF) | (sam_exp[c] & 16'hFF00);
    cmp_row(3, "R4 masked full write row content");
    chk(half_flag == 1 && sin_ready == 1 && sout_valid == 0, "R4 input mode, flag from tap",
        int'({half_flag, sin_ready, sout_valid}), 6);
    // R6 split write of upper half
    shift_in(6, 16'hC000);
    for (int i = 0; i < 6; i++) sam_exp[10 + i] = 16'hC000 + DW'(i);
    chk(half_flag == 0, "R8 flag flips on input side", half_flag, 0);
    idle(GAP);
    ras(1, 0, 1, 1, 1, 0, 0, 16'hFFFF, e1, e2);
    chk(e1 == 0, "R10 split write after window accepted", e1, 0);
    wait_free();
    for (int c = HW; c < WN; c++) ram_exp[0][c] = sam_exp[c];
    cmp_row(0, "R6 split write upper half only");
    // R6 split write of lower half under mask 0F0F
    shift_in(8, 16'hD000);
    for (int i = 0; i < 8; i++) sam_exp[i] = 16'hD000 + DW'(i);
    chk(half_flag == 1, "R8 flag after lower input half", half_flag, 1);
    idle(GAP);
    ras(1, 0, 1, 1, 0, 3, 0, 16'h0F0F, e1, e2);
    chk(e1 == 0, "R6 masked split write accepted", e1, 0);
    wait_free();
    for (int c = 0; c < HW; c++)
      ram_exp[3][c] = (ram_exp[3][c] & 16'hF0F0) | (sam_exp[c] & 16'h0F0F);
    cmp_row(3, "R6 masked split write lower half");
    cmp_row(1, "R11 untouched row 1");
    cmp_row(2, "R11 untouched row 2");
    idle(2);
    summary();
  end
endmodule